// File: doc/BRIEF.md
# Dual-Cache Method Queue

This block sits between a host register interface and a downstream execution engine. It buffers method writes (a method address, a 32-bit data word, a channel tag and a subchannel tag) and releases them to the engine through a valid/ready handshake. Two caches feed the output. A single-entry injection slot lets software place one method directly. A deep main queue, with its read and write indices kept in Gray code, holds the normal command stream.

Only one of eight channels is active at a time. A main-queue write whose channel tag differs from the active channel is dropped, and a sticky error bit is set. To change the active channel, software requests a context switch. The block then reports busy, refuses main-queue writes, and installs the new channel once the main queue has drained. A method placed in the injection slot takes the active channel as its tag. While the slot is occupied it is served before the main queue.

Top module: `mq_top`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `outValid`=0, `busy`=0, `chanErr`=0, `activeChan`=0, both Gray indices are 0, and `injReady`=1.
- R2: Main-queue entries leave at the output in the order they were accepted, with their address, data and subchannel unchanged.
- R3: Once DEPTH entries are held (DEPTH is 32 or 64), `full`=1 and `mainWrReady`=0. A write offered while full is not stored.
- R4: `wrIdxGray` and `rdIdxGray` are (log2(DEPTH)+1)-bit Gray codes of the running push and pop counts, modulo 2*DEPTH. Each step changes exactly one bit.
- R5: The injection slot holds one entry. While it is occupied, `injReady`=0, and its entry is presented at the output (`outFromInj`=1) ahead of any main-queue entry.
- R6: The injection slot becomes free (`injReady`=1) in the cycle after its entry is consumed.
- R7: A main-queue write whose channel tag is not `activeChan` is accepted but not stored, and it sets `chanErr`. `chanErr` stays set until `errClear` is pulsed.
- R8: A `ctxReq` pulse sets `busy` and drops `mainWrReady`. `activeChan` changes to `ctxChan` only after the main queue is empty, and `busy` then clears. `activeChan` never changes while `busy` is low.
- R9: The output `outChan` equals the channel tag of the delivered entry. An injected entry carries the channel that was active when it was injected.
- R10: With both caches empty, `outValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainWrValid | input | 1 | Main-queue write offer |
| mainWrReady | output | 1 | Main queue can take a write |
| mainWrChan | input | 3 | Channel tag of the write |
| mainWrSub | input | 3 | Subchannel tag of the write |
| mainWrAddr | input | 12 | Method address |
| mainWrData | input | 32 | Method data |
| injValid | input | 1 | Injection write offer |
| injReady | output | 1 | Injection slot is free |
| injSub | input | 3 | Subchannel of the injected method |
| injAddr | input | 12 | Address of the injected method |
| injData | input | 32 | Data of the injected method |
| ctxReq | input | 1 | Context-switch request pulse |
| ctxChan | input | 3 | Target channel of the switch |
| busy | output | 1 | Context switch pending |
| activeChan | output | 3 | Currently active channel |
| errClear | input | 1 | Clears the channel-mismatch error |
| chanErr | output | 1 | Sticky channel-mismatch error |
| outValid | output | 1 | Entry offered to the engine |
| outReady | input | 1 | Engine takes the entry |
| outFromInj | output | 1 | Offered entry comes from the injection slot |
| outChan | output | 3 | Channel tag of the offered entry |
| outSub | output | 3 | Subchannel tag of the offered entry |
| outAddr | output | 12 | Address of the offered entry |
| outData | output | 32 | Data of the offered entry |
| full | output | 1 | Main queue full |
| empty | output | 1 | Main queue empty |
| wrIdxGray | output | 6 | Gray-coded main-queue write index |
| rdIdxGray | output | 6 | Gray-coded main-queue read index |

## Verification
The main queue is exercised with a short burst of distinct data words, which exposes ordering and field-swap faults. It is also filled completely and then drained, which separates a correct full/empty comparison from one that is off by one or ignores the wrap bit. The Gray indices are read after known push and pop counts, which distinguishes a true Gray sequence from a binary count. Mixed traffic places an injection behind queued entries, to show whether the slot really takes priority. A mismatched-channel write and a switch requested with entries still queued show whether tags are checked against the active channel and whether the switch waits for the drain.

// File: rtl/mq_pkg.sv
package mq_pkg;
  parameter int MQ_CHAN_W = 3;
  parameter int MQ_SUB_W  = 3;
  parameter int MQ_ADDR_W = 12;
  parameter int MQ_DATA_W = 32;

  typedef struct packed {
    logic [MQ_CHAN_W-1:0] chan;
    logic [MQ_SUB_W-1:0]  sub;
    logic [MQ_ADDR_W-1:0] addr;
    logic [MQ_DATA_W-1:0] data;
  } mq_entry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pushMain;
    logic popMain;
    logic loadInj;
    logic popInj;
  } mq_strobe_t;
endpackage

// File: rtl/mq_dpath.sv
module mq_dpath
  import mq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  mq_strobe_t stb,
  input  mq_entry_t  mainIn,
  input  mq_entry_t  injIn,
  output mq_entry_t  headEntry,
  output mq_entry_t  injEntry,
  output logic       full,
  output logic       empty,
  output logic       injFull,
  output logic [PW-1:0] wrG,
  output logic [PW-1:0] rdG
);
  mq_entry_t mem [DEPTH];
  mq_entry_t injReg;
  logic      injV;
  logic [PW-1:0] wrB, rdB;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign wrB = g2b(wrG);
  assign rdB = g2b(rdG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrG <= '0;
      rdG <= '0;
    end else begin
      if (stb.pushMain) wrG <= b2g(wrB + 1'b1);
      if (stb.popMain)  rdG <= b2g(rdB + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.pushMain) mem[wrB[AW-1:0]] <= mainIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      injV   <= 1'b0;
      injReg <= '0;
    end else if (stb.loadInj) begin
      injV   <= 1'b1;
      injReg <= injIn;
    end else if (stb.popInj) begin
      injV   <= 1'b0;
    end
  end

  assign headEntry = mem[rdB[AW-1:0]];
  assign injEntry  = injReg;
  assign injFull   = injV;
  assign empty     = (wrG == rdG);
  assign full      = (wrG == {~rdG[PW-1:PW-2], rdG[PW-3:0]});
endmodule

// File: rtl/mq_ctrl.sv
module mq_ctrl
  import mq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mainWrValid,
  input  logic [MQ_CHAN_W-1:0] mainWrChan,
  input  logic       injValid,
  input  logic       ctxReq,
  input  logic [MQ_CHAN_W-1:0] ctxChan,
  input  logic       errClear,
  input  logic       outReady,
  input  logic       full,
  input  logic       empty,
  input  logic       injFull,
  output mq_strobe_t stb,
  output logic [MQ_CHAN_W-1:0] activeChan,
  output logic       busy,
  output logic       chanErr,
  output logic       mainWrReady,
  output logic       injReady,
  output logic       outValid,
  output logic       outFromInj
);
  logic [MQ_CHAN_W-1:0] curChan, tgtChan;
  logic pending, errReg;
  logic mainAcc, chanHit, outPop;

  assign mainWrReady = !full && !pending;
  assign mainAcc     = mainWrValid && mainWrReady;
  assign chanHit     = (mainWrChan == curChan);
  assign injReady    = !injFull;
  assign outValid    = injFull || !empty;
  assign outFromInj  = injFull;
  assign outPop      = outValid && outReady;

  always_comb begin
    stb          = '0;
    stb.pushMain = mainAcc && chanHit;
    stb.loadInj  = injValid && !injFull;
    stb.popInj   = outPop && injFull;
    stb.popMain  = outPop && !injFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curChan <= '0;
      tgtChan <= '0;
      pending <= 1'b0;
    end else if (pending) begin
      if (empty) begin
        curChan <= tgtChan;
        pending <= 1'b0;
      end
    end else if (ctxReq) begin
      tgtChan <= ctxChan;
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    errReg <= 1'b0;
    else if (mainAcc && !chanHit) errReg <= 1'b1;
    else if (errClear)            errReg <= 1'b0;
  end

  assign activeChan = curChan;
  assign busy       = pending;
  assign chanErr    = errReg;
endmodule

// File: rtl/mq_top.sv
module mq_top
  import mq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mainWrValid,
  output logic                 mainWrReady,
  input  logic [MQ_CHAN_W-1:0] mainWrChan,
  input  logic [MQ_SUB_W-1:0]  mainWrSub,
  input  logic [MQ_ADDR_W-1:0] mainWrAddr,
  input  logic [MQ_DATA_W-1:0] mainWrData,
  input  logic                 injValid,
  output logic                 injReady,
  input  logic [MQ_SUB_W-1:0]  injSub,
  input  logic [MQ_ADDR_W-1:0] injAddr,
  input  logic [MQ_DATA_W-1:0] injData,
  input  logic                 ctxReq,
  input  logic [MQ_CHAN_W-1:0] ctxChan,
  output logic                 busy,
  output logic [MQ_CHAN_W-1:0] activeChan,
  input  logic                 errClear,
  output logic                 chanErr,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outFromInj,
  output logic [MQ_CHAN_W-1:0] outChan,
  output logic [MQ_SUB_W-1:0]  outSub,
  output logic [MQ_ADDR_W-1:0] outAddr,
  output logic [MQ_DATA_W-1:0] outData,
  output logic                 full,
  output logic                 empty,
  output logic [PW-1:0]        wrIdxGray,
  output logic [PW-1:0]        rdIdxGray
);
  mq_strobe_t stb;
  mq_entry_t  mainIn, injIn, headEntry, injEntry, outEntry;
  logic       injFull;

  assign mainIn = '{chan: mainWrChan, sub: mainWrSub, addr: mainWrAddr, data: mainWrData};
  assign injIn  = '{chan: activeChan, sub: injSub, addr: injAddr, data: injData};

  mq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .mainWrValid(mainWrValid), .mainWrChan(mainWrChan),
    .injValid(injValid), .ctxReq(ctxReq), .ctxChan(ctxChan),
    .errClear(errClear), .outReady(outReady),
    .full(full), .empty(empty), .injFull(injFull),
    .stb(stb), .activeChan(activeChan), .busy(busy), .chanErr(chanErr),
    .mainWrReady(mainWrReady), .injReady(injReady),
    .outValid(outValid), .outFromInj(outFromInj)
  );

  mq_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .mainIn(mainIn), .injIn(injIn),
    .headEntry(headEntry), .injEntry(injEntry),
    .full(full), .empty(empty), .injFull(injFull),
    .wrG(wrIdxGray), .rdG(rdIdxGray)
  );

  assign outEntry = outFromInj ? injEntry : headEntry;
  assign outChan  = outEntry.chan;
  assign outSub   = outEntry.sub;
  assign outAddr  = outEntry.addr;
  assign outData  = outEntry.data;
endmodule

// File: rtl/mq_checker.sv
module mq_checker #(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          mainWrReady,
  input logic          injReady,
  input logic          busy,
  input logic [2:0]    activeChan,
  input logic          errClear,
  input logic          chanErr,
  input logic          outValid,
  input logic          outReady,
  input logic          outFromInj,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] wrIdxGray,
  input logic [PW-1:0] rdIdxGray
);
  initial p_depth_legal_r3: assert (DEPTH == 32 || DEPTH == 64);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !mainWrReady);
  p_not_both_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  p_wr_gray_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(wrIdxGray ^ $past(wrIdxGray)) <= 1);
  p_rd_gray_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(rdIdxGray ^ $past(rdIdxGray)) <= 1);
  p_inj_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    !injReady |-> (outValid && outFromInj));
  p_inj_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outFromInj) |=> injReady);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chanErr && !errClear) |=> chanErr);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !mainWrReady);
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(activeChan));
  p_idle_out_r10: assert property (@(posedge clk) disable iff (!rstN)
    (empty && injReady) |-> !outValid);
endmodule

bind mq_top mq_checker #(.DEPTH(DEPTH)) u_mq_checker (
  .clk(clk), .rstN(rstN), .mainWrReady(mainWrReady), .injReady(injReady),
  .busy(busy), .activeChan(activeChan), .errClear(errClear), .chanErr(chanErr),
  .outValid(outValid), .outReady(outReady), .outFromInj(outFromInj),
  .full(full), .empty(empty), .wrIdxGray(wrIdxGray), .rdIdxGray(rdIdxGray)
);

// File: tb/test_mq_top.sv
module test_mq_top;
  localparam int DEPTH = 32;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainWrValid = 0, injValid = 0, ctxReq = 0, errClear = 0, outReady = 0;
  logic [2:0] mainWrChan = 0, mainWrSub = 0, injSub = 0, ctxChan = 0;
  logic [11:0] mainWrAddr = 0, injAddr = 0;
  logic [31:0] mainWrData = 0, injData = 0;
  logic mainWrReady, injReady, busy, chanErr, outValid, outFromInj, full, empty;
  logic [2:0] activeChan, outChan, outSub;
  logic [11:0] outAddr;
  logic [31:0] outData;
  logic [PW-1:0] wrIdxGray, rdIdxGray;

  int checks = 0;
  int errors = 0;
  int pushCnt = 0;
  int popCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mq_top #(.DEPTH(DEPTH)) i_mq_top (
    .clk(clk), .rstN(rstN),
    .mainWrValid(mainWrValid), .mainWrReady(mainWrReady), .mainWrChan(mainWrChan),
    .mainWrSub(mainWrSub), .mainWrAddr(mainWrAddr), .mainWrData(mainWrData),
    .injValid(injValid), .injReady(injReady), .injSub(injSub), .injAddr(injAddr),
    .injData(injData), .ctxReq(ctxReq), .ctxChan(ctxChan), .busy(busy),
    .activeChan(activeChan), .errClear(errClear), .chanErr(chanErr),
    .outValid(outValid), .outReady(outReady), .outFromInj(outFromInj),
    .outChan(outChan), .outSub(outSub), .outAddr(outAddr), .outData(outData),
    .full(full), .empty(empty), .wrIdxGray(wrIdxGray), .rdIdxGray(rdIdxGray)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] gray(input int n);
    logic [PW-1:0] b;
    b = PW'(n % (2*DEPTH));
    return b ^ (b >> 1);
  endfunction

  // One write offer held for one clock edge
  task automatic pushMain(input logic [2:0] ch, input logic [2:0] sb,
                          input logic [11:0] ad, input logic [31:0] dt);
    @(negedge clk);
    mainWrValid = 1; mainWrChan = ch; mainWrSub = sb; mainWrAddr = ad; mainWrData = dt;
    if (mainWrReady && ch == activeChan) pushCnt++;
    @(negedge clk);
    mainWrValid = 0;
  endtask

  task automatic popExpect(input string req, input logic fromInj, input logic [2:0] ch,
                           input logic [2:0] sb, input logic [11:0] ad, input logic [31:0] dt);
    @(negedge clk);
    chk(req, "outValid", outValid, 1);
    chk(req, "outFromInj", outFromInj, fromInj);
    chk(req, "outChan", outChan, ch);
    chk(req, "outSub", outSub, sb);
    chk(req, "outAddr", outAddr, ad);
    chk(req, "outData", outData, dt);
    if (!fromInj) popCnt++;
    outReady = 1;
    @(negedge clk);
    outReady = 0;
  endtask

  task automatic injectOne(input logic [2:0] sb, input logic [11:0] ad, input logic [31:0] dt);
    @(negedge clk);
    injValid = 1; injSub = sb; injAddr = ad; injData = dt;
    @(negedge clk);
    injValid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "outValid", outValid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "chanErr", chanErr, 0);
    chk("R1", "activeChan", activeChan, 0);
    chk("R1", "wrIdxGray", wrIdxGray, 0);
    chk("R1", "rdIdxGray", rdIdxGray, 0);
    chk("R1", "injReady", injReady, 1);
    chk("R10", "outValid idle", outValid, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 4; i++)
      pushMain(3'd0, 3'(i + 1), 12'(12'h100 + i), 32'hA5A50000 + i);
    chk("R4", "wrIdxGray after 4", wrIdxGray, gray(pushCnt));
    for (int i = 0; i < 4; i++)
      popExpect("R2", 0, 3'd0, 3'(i + 1), 12'(12'h100 + i), 32'hA5A50000 + i);
    @(negedge clk);
    chk("R4", "rdIdxGray after 4", rdIdxGray, gray(popCnt));
    chk("R10", "outValid drained", outValid, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++)
      pushMain(3'd0, 3'(i), 12'(i), 32'h1000 + i);
    @(negedge clk);
    chk("R3", "full", full, 1);
    chk("R3", "mainWrReady", mainWrReady, 0);
    pushMain(3'd0, 3'd7, 12'hFFF, 32'hDEADBEEF);
    chk("R3", "full still", full, 1);
    chk("R4", "wrIdxGray full", wrIdxGray, gray(pushCnt));
    for (int i = 0; i < DEPTH; i++)
      popExpect("R3", 0, 3'd0, 3'(i), 12'(i), 32'h1000 + i);
    @(negedge clk);
    chk("R3", "empty after drain", empty, 1);
    chk("R4", "rdIdxGray wrap", rdIdxGray, gray(popCnt));
  endtask

  task automatic t_inject;
    pushMain(3'd0, 3'd2, 12'h200, 32'h22);
    injectOne(3'd5, 12'h3AB, 32'hCAFE0001);
    chk("R5", "injReady occupied", injReady, 0);
    @(negedge clk);
    injValid = 1; injSub = 3'd6; injAddr = 12'h111; injData = 32'h0BAD;
    @(negedge clk);
    injValid = 0;
    popExpect("R5", 1, 3'd0, 3'd5, 12'h3AB, 32'hCAFE0001);
    chk("R6", "injReady freed", injReady, 1);
    popExpect("R9", 0, 3'd0, 3'd2, 12'h200, 32'h22);
    @(negedge clk);
    chk("R10", "idle after inject", outValid, 0);
  endtask

  task automatic t_mismatch;
    pushMain(3'd3, 3'd1, 12'h055, 32'h55);
    chk("R7", "chanErr set", chanErr, 1);
    chk("R7", "not stored", empty, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R7", "chanErr sticky", chanErr, 1);
    errClear = 1;
    @(negedge clk);
    errClear = 0;
    chk("R7", "chanErr cleared", chanErr, 0);
  endtask

  task automatic t_ctx;
    pushMain(3'd0, 3'd1, 12'h0A1, 32'h71);
    pushMain(3'd0, 3'd2, 12'h0A2, 32'h72);
    @(negedge clk);
    ctxReq = 1; ctxChan = 3'd5;
    @(negedge clk);
    ctxReq = 0;
    chk("R8", "busy", busy, 1);
    chk("R8", "mainWrReady blocked", mainWrReady, 0);
    chk("R8", "activeChan held", activeChan, 0);
    popExpect("R8", 0, 3'd0, 3'd1, 12'h0A1, 32'h71);
    chk("R8", "activeChan mid-drain", activeChan, 0);
    popExpect("R8", 0, 3'd0, 3'd2, 12'h0A2, 32'h72);
    @(negedge clk);
    chk("R8", "activeChan switched", activeChan, 5);
    chk("R8", "busy cleared", busy, 0);
    injectOne(3'd4, 12'h0C4, 32'h44);
    popExpect("R9", 1, 3'd5, 3'd4, 12'h0C4, 32'h44);
    pushMain(3'd5, 3'd3, 12'h0B3, 32'h53);
    chk("R7", "no error on match", chanErr, 0);
    popExpect("R9", 0, 3'd5, 3'd3, 12'h0B3, 32'h53);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_order();
    t_full();
    t_inject();
    t_mismatch();
    t_ctx();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule